// File: doc/BRIEF.md
# Interrupt Queue Event Writer

This block turns per-channel events into entries in four circular interrupt queues. Each incoming event names a channel and an event kind: receive buffer, receive frame or transmit buffer. A per-channel configuration word holds an enable bit for each kind and the number of the queue that receives that channel's events. An accepted event is written, with its opaque payload, at the queue's write pointer, and that entry is marked valid. Every entry also carries a wrap bit. After the block writes an entry whose wrap bit is set, the pointer returns to entry zero. If the pointer lands on an entry that is still valid, the event is dropped and the queue's overflow flag is raised.

Each queue has a countdown that coalesces interrupts. Every accepted event decrements it. When it reaches zero, the queue's global interrupt flag is set and the countdown reloads from a programmable threshold. A single host port reads entries, clears valid bits, sets wrap bits, clears flags, and programs thresholds, channel words and interrupt masks. The interrupt output is a registered OR of the flags that are enabled by the mask.

Top module: `iq_event_writer`

## Requirements
- R1: After synchronous reset all flags and `irq` are 0, every entry is invalid, every write pointer is 0, all channel enables and masks are 0, every threshold and countdown equals `DEF_THR`, and only the last entry of each queue has its wrap bit set.
- R2: Host op 6 (channel config) writes channel `host_wdata[5 +: CHW]` with queue `host_wdata[QW-1:0]` and enables `host_wdata[4:2]` (bit 2 receive buffer, bit 3 receive frame, bit 4 transmit buffer). An event of type 0, 1 or 2 whose enable bit is set is accepted and routed to that channel's queue.
- R3: An event of type 3, or of a type whose enable bit is clear, writes no entry, leaves the pointer unchanged and does not decrement the countdown.
- R4: An accepted event that finds an invalid entry at the pointer stores its payload there with valid set, and the pointer advances by one.
- R5: After the block stores into an entry whose wrap bit is 1, or into the last entry, the pointer becomes 0. Host op 3 sets the wrap bit of entry `host_idx` of queue `host_q` to `host_wdata[0]`.
- R6: An accepted event that finds a valid entry at the pointer leaves that entry unchanged, leaves the pointer unchanged, sets the queue's overflow flag, and still decrements the countdown.
- R7: When an accepted event brings the countdown to zero, the queue's global interrupt flag is set in the same clock and the countdown reloads from the threshold. Host op 5 writes the threshold from `host_wdata[THR_W-1:0]` and also reloads the countdown. A threshold of 0 acts as 1.
- R8: Host op 4 clears global interrupt flag q where `host_wdata[q]` is 1 and overflow flag q where `host_wdata[NUM_Q+q]` is 1. A set in the same cycle wins over the clear.
- R9: Host op 2 clears the valid bit of entry `host_idx` of queue `host_q`.
- R10: Host op 7 writes the global-interrupt mask from `host_wdata[NUM_Q-1:0]` and the overflow mask from `host_wdata[2*NUM_Q-1:NUM_Q]`. `irq` is the OR of every flag ANDed with its mask bit, registered one cycle after the flags.
- R11: Host op 1 reads entry `host_idx` of queue `host_q`. In the next cycle `host_rdata` holds valid in bit PW+1, wrap in bit PW and the payload in bits PW-1:0. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_chan | input | CHW | Source channel of the event |
| ev_type | input | 2 | 0 receive buffer, 1 receive frame, 2 transmit buffer, 3 none |
| ev_payload | input | PW | Opaque entry contents |
| host_valid | input | 1 | Host operation present this cycle |
| host_op | input | 3 | Host operation code |
| host_q | input | QW | Queue addressed by the host |
| host_idx | input | IW | Entry addressed by the host |
| host_wdata | input | HW | Host write data |
| host_rdata | output | PW+2 | Registered read data |
| gint_flags | output | NUM_Q | Global interrupt flag per queue |
| ovf_flags | output | NUM_Q | Overflow flag per queue |
| irq | output | 1 | Masked interrupt request |

## Verification
Events and host writes take effect at the clock edge that samples them. The flags, the stored entries and the pointers therefore change at that edge. `irq` changes one edge later, and read data appears one edge after the read op. The bench drives on the falling edge. It checks the flags at the next falling edge, the interrupt output one falling edge after that, and read data at the falling edge that follows the read op. Entry contents and pointer moves are checked by reads through the host port, compared against a queue model that the bench keeps from the requirements.

// File: rtl/iq_pkg.sv
package iq_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_CLRV  = 3'd2,
    OP_WRAP  = 3'd3,
    OP_CLRF  = 3'd4,
    OP_THR   = 3'd5,
    OP_CHAN  = 3'd6,
    OP_MASK  = 3'd7
  } host_op_e;

  typedef enum logic [1:0] {
    EV_RXBUF   = 2'd0,
    EV_RXFRAME = 2'd1,
    EV_TXBUF   = 2'd2,
    EV_NONE    = 2'd3
  } ev_kind_e;

  localparam int CFG_EN_LSB = 2;
  localparam int CFG_CH_LSB = 5;

endpackage

// File: rtl/iq_chan_cfg.sv
module iq_chan_cfg #(
  parameter int NUM_CH = 8,
  parameter int NUM_Q  = 4,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [QW-1:0]    cfg_q,
  input  logic [2:0]       cfg_en,
  input  logic             ev_valid,
  input  logic [CHW-1:0]   ev_chan,
  input  logic [1:0]       ev_type,
  output logic [NUM_Q-1:0] q_hit
);
  import iq_pkg::*;

  logic [2:0]    en_q   [NUM_CH];
  logic [QW-1:0] qsel_q [NUM_CH];
  logic          kind_on;
  logic          accept;
  logic [2:0]    en_cur;
  logic [QW-1:0] q_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        en_q[c]   <= '0;
        qsel_q[c] <= '0;
      end
    end else if (cfg_we) begin
      en_q[cfg_ch]   <= cfg_en;
      qsel_q[cfg_ch] <= cfg_q;
    end
  end

  assign en_cur = en_q[ev_chan];
  assign q_cur  = qsel_q[ev_chan];

  always_comb begin
    case (ev_type)
      EV_RXBUF:   kind_on = en_cur[0];
      EV_RXFRAME: kind_on = en_cur[1];
      EV_TXBUF:   kind_on = en_cur[2];
      default:    kind_on = 1'b0;
    endcase
  end

  assign accept = ev_valid & kind_on;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_hit
    assign q_hit[g] = accept && (q_cur == QW'(g));
  end

endmodule

// File: rtl/iq_queue.sv
module iq_queue #(
  parameter int DEPTH   = 16,
  parameter int PW      = 32,
  parameter int THR_W   = 8,
  parameter int DEF_THR = 1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_we,
  input  logic [PW-1:0]    ev_payload,
  input  logic [IW-1:0]    host_idx,
  input  logic             rd_en,
  input  logic             clrv_we,
  input  logic             wrap_we,
  input  logic             wrap_val,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_val,
  input  logic             gint_clr,
  input  logic             ovf_clr,
  output logic [PW+1:0]    rd_data,
  output logic             gint,
  output logic             ovf
);

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] wrap_q;
  logic [IW-1:0]    ptr_q;
  logic [THR_W-1:0] thr_q;
  logic [THR_W-1:0] cnt_q;
  logic [PW-1:0]    mem [DEPTH];
  logic [PW-1:0]    mem_rd;
  logic             vb_rd;
  logic             wb_rd;

  logic             slot_busy;
  logic             store;
  logic             ovf_set;
  logic             at_end;
  logic [IW-1:0]    ptr_nxt;
  logic [THR_W-1:0] thr_load;
  logic             cnt_hit;
  logic             gint_set;
  logic [DEPTH-1:0] set_vec;
  logic [DEPTH-1:0] clr_vec;

  assign slot_busy = valid_q[ptr_q];
  assign store     = ev_we & ~slot_busy;
  assign ovf_set   = ev_we & slot_busy;
  assign at_end    = wrap_q[ptr_q] | (ptr_q == IW'(DEPTH - 1));
  assign ptr_nxt   = at_end ? '0 : ptr_q + 1'b1;
  assign thr_load  = (thr_val == '0) ? THR_W'(1) : thr_val;
  assign cnt_hit   = (cnt_q <= THR_W'(1));
  assign gint_set  = ev_we & ~thr_we & cnt_hit;
  assign set_vec   = store   ? (DEPTH'(1) << ptr_q)    : '0;
  assign clr_vec   = clrv_we ? (DEPTH'(1) << host_idx) : '0;

  // payload storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (store) mem[ptr_q] <= ev_payload;
    if (rd_en) mem_rd <= mem[host_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      wrap_q  <= DEPTH'(1) << (DEPTH - 1);
      ptr_q   <= '0;
      thr_q   <= THR_W'(DEF_THR);
      cnt_q   <= THR_W'(DEF_THR);
      gint    <= 1'b0;
      ovf     <= 1'b0;
      vb_rd   <= 1'b0;
      wb_rd   <= 1'b0;
    end else begin
      valid_q <= (valid_q & ~clr_vec) | set_vec;
      if (wrap_we) wrap_q[host_idx] <= wrap_val;
      if (store) ptr_q <= ptr_nxt;
      if (thr_we) begin
        thr_q <= thr_load;
        cnt_q <= thr_load;
      end else if (ev_we) begin
        cnt_q <= cnt_hit ? thr_q : cnt_q - 1'b1;
      end
      gint <= (gint & ~gint_clr) | gint_set;
      ovf  <= (ovf & ~ovf_clr) | ovf_set;
      if (rd_en) begin
        vb_rd <= valid_q[host_idx];
        wb_rd <= wrap_q[host_idx];
      end
    end
  end

  assign rd_data = {vb_rd, wb_rd, mem_rd};

endmodule

// File: rtl/iq_irq.sv
module iq_irq #(
  parameter int NUM_Q = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [NUM_Q-1:0] gmask_val,
  input  logic [NUM_Q-1:0] omask_val,
  input  logic [NUM_Q-1:0] gint,
  input  logic [NUM_Q-1:0] ovf,
  output logic [NUM_Q-1:0] gint_msk,
  output logic [NUM_Q-1:0] ovf_msk,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      gint_msk <= '0;
      ovf_msk  <= '0;
      irq      <= 1'b0;
    end else begin
      if (mask_we) begin
        gint_msk <= gmask_val;
        ovf_msk  <= omask_val;
      end
      irq <= |((gint & gint_msk) | (ovf & ovf_msk));
    end
  end

endmodule

// File: rtl/iq_event_writer.sv
module iq_event_writer #(
  parameter int NUM_Q   = 4,
  parameter int DEPTH   = 16,
  parameter int PW      = 32,
  parameter int THR_W   = 8,
  parameter int NUM_CH  = 8,
  parameter int DEF_THR = 1,
  localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int HW0 = (5 + CHW > 2 * NUM_Q) ? 5 + CHW : 2 * NUM_Q,
  localparam int HW  = (HW0 > THR_W) ? HW0 : THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [CHW-1:0]   ev_chan,
  input  logic [1:0]       ev_type,
  input  logic [PW-1:0]    ev_payload,
  input  logic             host_valid,
  input  logic [2:0]       host_op,
  input  logic [QW-1:0]    host_q,
  input  logic [IW-1:0]    host_idx,
  input  logic [HW-1:0]    host_wdata,
  output logic [PW+1:0]    host_rdata,
  output logic [NUM_Q-1:0] gint_flags,
  output logic [NUM_Q-1:0] ovf_flags,
  output logic             irq
);
  import iq_pkg::*;

  logic             op_read, op_clrv, op_wrap, op_clrf, op_thr, op_chan, op_mask;
  logic [NUM_Q-1:0] q_hit;
  logic [NUM_Q-1:0] gint_msk;
  logic [NUM_Q-1:0] ovf_msk;
  logic [PW+1:0]    rd_bus [NUM_Q];
  logic [QW-1:0]    rd_sel_q;

  assign op_read = host_valid && (host_op == OP_READ);
  assign op_clrv = host_valid && (host_op == OP_CLRV);
  assign op_wrap = host_valid && (host_op == OP_WRAP);
  assign op_clrf = host_valid && (host_op == OP_CLRF);
  assign op_thr  = host_valid && (host_op == OP_THR);
  assign op_chan = host_valid && (host_op == OP_CHAN);
  assign op_mask = host_valid && (host_op == OP_MASK);

  iq_chan_cfg #(
    .NUM_CH (NUM_CH),
    .NUM_Q  (NUM_Q)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (op_chan),
    .cfg_ch   (host_wdata[CFG_CH_LSB +: CHW]),
    .cfg_q    (host_wdata[QW-1:0]),
    .cfg_en   (host_wdata[CFG_EN_LSB +: 3]),
    .ev_valid (ev_valid),
    .ev_chan  (ev_chan),
    .ev_type  (ev_type),
    .q_hit    (q_hit)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic sel;
    assign sel = (host_q == QW'(g));

    iq_queue #(
      .DEPTH   (DEPTH),
      .PW      (PW),
      .THR_W   (THR_W),
      .DEF_THR (DEF_THR)
    ) u_queue (
      .clk        (clk),
      .rst        (rst),
      .ev_we      (q_hit[g]),
      .ev_payload (ev_payload),
      .host_idx   (host_idx),
      .rd_en      (op_read & sel),
      .clrv_we    (op_clrv & sel),
      .wrap_we    (op_wrap & sel),
      .wrap_val   (host_wdata[0]),
      .thr_we     (op_thr & sel),
      .thr_val    (host_wdata[THR_W-1:0]),
      .gint_clr   (op_clrf & host_wdata[g]),
      .ovf_clr    (op_clrf & host_wdata[NUM_Q + g]),
      .rd_data    (rd_bus[g]),
      .gint       (gint_flags[g]),
      .ovf        (ovf_flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= '0;
    else if (op_read) rd_sel_q <= host_q;
  end

  assign host_rdata = rd_bus[rd_sel_q];

  iq_irq #(
    .NUM_Q (NUM_Q)
  ) u_irq (
    .clk       (clk),
    .rst       (rst),
    .mask_we   (op_mask),
    .gmask_val (host_wdata[NUM_Q-1:0]),
    .omask_val (host_wdata[2*NUM_Q-1:NUM_Q]),
    .gint      (gint_flags),
    .ovf       (ovf_flags),
    .gint_msk  (gint_msk),
    .ovf_msk   (ovf_msk),
    .irq       (irq)
  );

endmodule

// File: rtl/iq_event_writer_chk.sv
module iq_event_writer_chk #(
  parameter int NUM_Q = 4,
  parameter int HW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [1:0]       ev_type,
  input logic             host_valid,
  input logic [2:0]       host_op,
  input logic [HW-1:0]    host_wdata,
  input logic [NUM_Q-1:0] gint_flags,
  input logic [NUM_Q-1:0] ovf_flags,
  input logic [NUM_Q-1:0] gint_msk,
  input logic [NUM_Q-1:0] ovf_msk,
  input logic             irq
);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      reset_state_chk: assert (gint_flags == '0 && ovf_flags == '0 && !irq)
        else $error("flags or irq not clear after reset");
    end
  end

  // R3
  masked_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_type == 2'd3)
    |=> (((gint_flags & ~$past(gint_flags)) == '0) &&
         ((ovf_flags & ~$past(ovf_flags)) == '0)));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_op == 3'd4 && !ev_valid)
    |=> (((gint_flags & $past(host_wdata[NUM_Q-1:0])) == '0) &&
         ((ovf_flags & $past(host_wdata[2*NUM_Q-1:NUM_Q])) == '0)));

  // R8
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_valid
    |=> (((gint_flags & ~$past(gint_flags)) == '0) &&
         ((ovf_flags & ~$past(ovf_flags)) == '0)));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1
    |=> (irq == |(($past(gint_flags) & $past(gint_msk)) |
                  ($past(ovf_flags) & $past(ovf_msk)))));

endmodule

bind iq_event_writer iq_event_writer_chk #(.NUM_Q(NUM_Q), .HW(HW)) u_chk (.*);

// File: tb/iq_event_writer_tb.sv
module iq_event_writer_tb;
  import iq_pkg::*;

  localparam int NQ  = 4;
  localparam int DEP = 4;
  localparam int PW  = 8;
  localparam int TW  = 3;
  localparam int NCH = 4;
  localparam int QW  = 2;
  localparam int IW  = 2;
  localparam int CHW = 2;
  localparam int HW  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst;
  logic            ev_valid;
  logic [CHW-1:0]  ev_chan;
  logic [1:0]      ev_type;
  logic [PW-1:0]   ev_payload;
  logic            host_valid;
  logic [2:0]      host_op;
  logic [QW-1:0]   host_q;
  logic [IW-1:0]   host_idx;
  logic [HW-1:0]   host_wdata;
  logic [PW+1:0]   host_rdata;
  logic [NQ-1:0]   gint_flags;
  logic [NQ-1:0]   ovf_flags;
  logic            irq;

  iq_event_writer #(
    .NUM_Q(NQ), .DEPTH(DEP), .PW(PW), .THR_W(TW), .NUM_CH(NCH), .DEF_THR(1)
  ) u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bit           mval  [NQ][DEP];
  bit           mwrap [NQ][DEP];
  logic [PW-1:0] mpay [NQ][DEP];
  int           mptr [NQ];
  int           mcnt [NQ];
  int           mthr [NQ];
  int           cq   [NCH];
  bit [2:0]     cen  [NCH];
  bit [NQ-1:0]  mg, mo, mgm, mom;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq();
    return |((mg & mgm) | (mo & mom));
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic do_host(input logic [2:0] op, input int q, input int idx, input int wd);
    @(negedge clk);
    host_valid = 1'b1;
    host_op    = op;
    host_q     = QW'(q);
    host_idx   = IW'(idx);
    host_wdata = HW'(wd);
    @(negedge clk);
    host_valid = 1'b0;
    host_op    = OP_NOP;
  endtask

  function automatic void model_ev(input int ch, input int typ, input logic [PW-1:0] pay);
    int q;
    if (typ == 3 || !cen[ch][typ]) return;
    q = cq[ch];
    if (mcnt[q] <= 1) begin
      mg[q]   = 1'b1;
      mcnt[q] = eff(mthr[q]);
    end else begin
      mcnt[q]--;
    end
    if (mval[q][mptr[q]]) begin
      mo[q] = 1'b1;
    end else begin
      mval[q][mptr[q]] = 1'b1;
      mpay[q][mptr[q]] = pay;
      if (mwrap[q][mptr[q]] || mptr[q] == DEP - 1) mptr[q] = 0;
      else mptr[q]++;
    end
  endfunction

  task automatic send_ev(input int ch, input int typ, input int pay, input string tag);
    @(negedge clk);
    ev_valid   = 1'b1;
    ev_chan    = CHW'(ch);
    ev_type    = 2'(typ);
    ev_payload = PW'(pay);
    @(negedge clk);
    ev_valid = 1'b0;
    model_ev(ch, typ, PW'(pay));
    chk({tag, " gint"}, 64'(gint_flags), 64'(mg));
    chk({tag, " ovf"}, 64'(ovf_flags), 64'(mo));
    @(negedge clk);
    chk("R10 irq after event", 64'(irq), 64'(exp_irq()));
  endtask

  task automatic read_chk(input int q, input int idx, input string tag);
    do_host(OP_READ, q, idx, 0);
    chk(tag, 64'(host_rdata), 64'({mval[q][idx], mwrap[q][idx], mpay[q][idx]}));
  endtask

  task automatic drain(input int q, input string tag);
    for (int i = 0; i < DEP; i++) read_chk(q, i, tag);
    for (int i = 0; i < DEP; i++) begin
      if (mval[q][i]) begin
        do_host(OP_CLRV, q, i, 0);
        mval[q][i] = 1'b0;
      end
    end
    read_chk(q, 0, "R9 valid cleared");
  endtask

  task automatic set_chan(input int ch, input int q, input int en);
    do_host(OP_CHAN, 0, 0, (ch << 5) | (en << 2) | q);
    cq[ch]  = q;
    cen[ch] = 3'(en);
  endtask

  task automatic set_thr(input int q, input int v);
    do_host(OP_THR, q, 0, v);
    mthr[q] = v;
    mcnt[q] = eff(v);
  endtask

  task automatic clr_flags(input bit [NQ-1:0] g, input bit [NQ-1:0] o);
    do_host(OP_CLRF, 0, 0, {o, g});
    mg &= ~g;
    mo &= ~o;
    chk("R8 gint after clear", 64'(gint_flags), 64'(mg));
    chk("R8 ovf after clear", 64'(ovf_flags), 64'(mo));
    @(negedge clk);
  endtask

  task automatic set_mask(input int m);
    do_host(OP_MASK, 0, 0, m);
    mgm = NQ'(m);
    mom = NQ'(m >> NQ);
    @(negedge clk);
    chk("R10 irq after mask", 64'(irq), 64'(exp_irq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ev_valid = 1'b0; ev_chan = '0; ev_type = '0; ev_payload = '0;
    host_valid = 1'b0; host_op = OP_NOP; host_q = '0; host_idx = '0; host_wdata = '0;
    for (int q = 0; q < NQ; q++) begin
      mptr[q] = 0; mcnt[q] = 1; mthr[q] = 1;
      for (int i = 0; i < DEP; i++) begin
        mval[q][i] = 1'b0; mwrap[q][i] = (i == DEP - 1); mpay[q][i] = '0;
      end
    end
    for (int c = 0; c < NCH; c++) begin cq[c] = 0; cen[c] = '0; end
    mg = '0; mo = '0; mgm = '0; mom = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 gint reset", 64'(gint_flags), 64'(0));
    chk("R1 ovf reset", 64'(ovf_flags), 64'(0));
    chk("R1 irq reset", 64'(irq), 64'(0));
    // R1 R11: entries invalid, wrap only on last entry; payload not yet written
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < DEP; i++) begin
        do_host(OP_READ, q, i, 0);
        chk("R1 R11 reset entry flags", 64'(host_rdata[PW+1:PW]), 64'({1'b0, i == DEP - 1}));
      end
    // R3: enables are 0 after reset, so nothing is accepted
    send_ev(0, 0, 8'h11, "R3 reset-masked");
    read_chk(0, 0, "R3 no entry while masked");

    // R2 R3 R4 R5: sweep channels, enable patterns and event types
    for (int ch = 0; ch < NCH; ch++) begin
      for (int en = 0; en < 8; en++) begin
        set_chan(ch, ch, en);
        for (int typ = 0; typ < 4; typ++)
          send_ev(ch, typ, ch * 32 + en * 4 + typ, "R2 R3 sweep");
        drain(ch, "R2 R4 R5 R11 sweep entry");
      end
      clr_flags(NQ'(1 << ch), '0);
    end

    // R6 R7: overflow on queue 0 with threshold 3
    set_chan(0, 0, 7);
    set_thr(0, 3);
    for (int k = 0; k < 6; k++) send_ev(0, k % 3, 8'h40 + k, "R6 R7 fill");
    for (int i = 0; i < DEP; i++) read_chk(0, i, "R6 entry kept");
    clr_flags(4'b0001, 4'b0001);
    do_host(OP_CLRV, 0, mptr[0], 0);
    mval[0][mptr[0]] = 1'b0;
    send_ev(0, 0, 8'h5a, "R4 after slot freed");
    read_chk(0, (mptr[0] + DEP - 1) % DEP, "R4 slot reused");
    drain(0, "R6 drain");

    // R5: wrap bit on entry 1 of queue 1
    set_chan(1, 1, 7);
    do_host(OP_WRAP, 1, 1, 1);
    mwrap[1][1] = 1'b1;
    read_chk(1, 1, "R5 wrap bit set");
    for (int k = 0; k < 6; k++) begin
      send_ev(1, 1, 8'h70 + k, "R5 wrap walk");
      drain(1, "R5 wrap entry");
    end
    do_host(OP_WRAP, 1, 1, 0);
    mwrap[1][1] = 1'b0;
    read_chk(1, 1, "R5 wrap bit cleared");

    // R7: threshold 0 acts as 1, threshold write reloads the countdown
    set_chan(2, 2, 7);
    set_thr(2, 0);
    clr_flags(4'b0100, '0);
    send_ev(2, 2, 8'h21, "R7 thr0 first");
    clr_flags(4'b0100, '0);
    send_ev(2, 2, 8'h22, "R7 thr0 second");
    drain(2, "R7 drain");
    set_chan(3, 3, 7);
    set_thr(3, 2);
    clr_flags(4'b1000, '0);
    send_ev(3, 0, 8'h31, "R7 countdown 2->1");
    set_thr(3, 2);
    send_ev(3, 0, 8'h32, "R7 reload then 2->1");
    send_ev(3, 0, 8'h33, "R7 reaches zero");
    drain(3, "R7 drain q3");

    // R8: set in the same cycle as a clear wins
    set_thr(0, 1);
    @(negedge clk);
    ev_valid = 1'b1; ev_chan = 0; ev_type = 0; ev_payload = 8'h99;
    host_valid = 1'b1; host_op = OP_CLRF; host_wdata = 8'h01;
    @(negedge clk);
    ev_valid = 1'b0; host_valid = 1'b0; host_op = OP_NOP;
    mg[0] = 1'b0;
    model_ev(0, 0, 8'h99);
    chk("R8 set wins over clear", 64'(gint_flags), 64'(mg));
    drain(0, "R8 drain");

    // R10: mask sweep with some flags set
    set_thr(1, 1);
    send_ev(1, 0, 8'h01, "R10 prep q1");
    send_ev(1, 0, 8'h02, "R10 prep q1");
    for (int m = 0; m < 256; m++) set_mask(m);
    clr_flags('1, '1);
    set_mask(8'hff);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule